// File: doc/BRIEF.md
# Bit-Serial Adder with Carry State

This block adds two 4-bit unsigned operands over several clocks with a single one-bit adder cell. A strobe captures both operands into shift registers that hand the cell their low bits first. Each clock the cell combines one bit from each operand with the stored carry. The sum bit enters the result register from its top end, and the new carry goes back into a one-bit flip-flop. That flip-flop is the only state the arithmetic keeps between steps.

After four steps the result register holds the whole sum, and the carry flip-flop holds the carry out of the top bit. A one-cycle completion flag then rises. The result and carry stay on the outputs until the next accepted strobe. A strobe is taken when the block is idle or showing completion. A strobe that arrives while bits are still being added has no effect.

Top module: `ser_adder`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `sumOut` is 0, `carryOut` is 0 and `done` is 0.
- R2: In the cycle where `done` is 1, `sumOut` equals (opA + opB) mod 16 for the operands that were captured by the accepted strobe.
- R3: In the cycle where `done` is 1, `carryOut` equals bit 4 of the 5-bit sum opA + opB, so it is 1 exactly when opA + opB > 15.
- R4: `done` rises on the fourth rising edge after the edge that accepted a strobe. It is low on the three edges before that, and it stays high for exactly one cycle.
- R5: An accepted strobe sets `sumOut` to 0 and `carryOut` to 0 on the edge that accepts it.
- R6: A strobe that arrives while an addition is in progress is ignored. The running addition finishes at its original time with its original operands.
- R7: A strobe presented in the cycle where `done` is 1 is accepted, and it starts a new addition without an idle cycle in between.
- R8: The low operand bits are consumed first. After k steps (k = 1..3), bits [3:4-k] of `sumOut` hold bits [k-1:0] of opA + opB.
- R9: When no strobe is present, `sumOut` and `carryOut` keep their values through the completion cycle and every idle cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| loadStb | input | 1 | Strobe that captures the operands and starts an addition |
| opA | input | 4 | First operand, sampled only with an accepted strobe |
| opB | input | 4 | Second operand, sampled only with an accepted strobe |
| sumOut | output | 4 | Result register; valid while `done` is 1 and held afterwards |
| carryOut | output | 1 | Carry flip-flop; carry out of bit 3 once the addition completes |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that reset is held for at least two clock edges, which gives the outputs a defined value before the first check. They also assume that the operands are valid in the cycle a strobe is accepted. The operands are free at all other times, and the checker only captures them on acceptance. The stimulus changes every input at the falling edge, so each strobe is one clean cycle wide. Operands are deliberately changed together with a strobe that lands mid-addition, which exercises the ignore path while keeping these assumptions.

// File: rtl/ser_adder_pkg.sv
package ser_adder_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture operands, clear carry and result
    logic shift;  // perform one bit step
  } dpCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } ctlState_e;

endpackage

// File: rtl/ser_fa_cell.sv
module ser_fa_cell (
  input  logic aBit,
  input  logic bBit,
  input  logic cIn,
  output logic sBit,
  output logic cOut
);
  logic gen;
  logic prop;

  assign gen  = aBit & bBit;
  assign prop = aBit ^ bBit;
  assign sBit = prop ^ cIn;
  assign cOut = gen | (prop & cIn);
endmodule

// File: rtl/ser_adder_dp.sv
module ser_adder_dp
  import ser_adder_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  dpCtrl_t          ctrl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  logic [WIDTH-1:0] shA;
  logic [WIDTH-1:0] shB;
  logic [WIDTH-1:0] resReg;
  logic             carryReg;
  logic             stepSum;
  logic             stepCarry;

  // the single adder cell shared by every bit position
  ser_fa_cell u_cell (
    .aBit (shA[0]),
    .bBit (shB[0]),
    .cIn  (carryReg),
    .sBit (stepSum),
    .cOut (stepCarry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      shA      <= '0;
      shB      <= '0;
      resReg   <= '0;
      carryReg <= 1'b0;
    end else if (ctrl.load) begin
      shA      <= opA;
      shB      <= opB;
      resReg   <= '0;
      carryReg <= 1'b0;
    end else if (ctrl.shift) begin
      shA      <= shA >> 1;
      shB      <= shB >> 1;
      resReg   <= {stepSum, resReg[WIDTH-1:1]};
      carryReg <= stepCarry;
    end
  end

  assign sumOut   = resReg;
  assign carryOut = carryReg;
endmodule

// File: rtl/ser_adder_ctl.sv
module ser_adder_ctl
  import ser_adder_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    loadStb,
  output dpCtrl_t ctrl,
  output logic    done
);
  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  ctlState_e        state;
  logic [CNT_W-1:0] stepCnt;
  logic             acceptLoad;

  assign acceptLoad = loadStb && (state != ST_BUSY);

  always_comb begin
    ctrl       = '0;
    ctrl.load  = acceptLoad;
    ctrl.shift = (state == ST_BUSY);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      case (state)
        ST_BUSY: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST_STEP) begin
            state <= ST_DONE;
          end
        end
        ST_DONE: begin
          stepCnt <= '0;
          state   <= acceptLoad ? ST_BUSY : ST_IDLE;
        end
        default: begin
          stepCnt <= '0;
          state   <= acceptLoad ? ST_BUSY : ST_IDLE;
        end
      endcase
    end
  end

  assign done = (state == ST_DONE);
endmodule

// File: rtl/ser_adder.sv
module ser_adder
  import ser_adder_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadStb,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut,
  output logic             done
);
  dpCtrl_t ctrl;

  ser_adder_ctl #(.WIDTH(WIDTH)) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .loadStb (loadStb),
    .ctrl    (ctrl),
    .done    (done)
  );

  ser_adder_dp #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .opA      (opA),
    .opB      (opB),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );
endmodule

// File: rtl/ser_adder_chk.sv
module ser_adder_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             loadStb,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [WIDTH-1:0] sumOut,
  input logic             carryOut,
  input logic             done
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [CW-1:0]  stepsLeft;
  logic [WIDTH:0] expTotal;
  logic           taken;

  assign taken = loadStb && (stepsLeft == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      stepsLeft <= '0;
      expTotal  <= '0;
    end else if (taken) begin
      stepsLeft <= CW'(WIDTH);
      expTotal  <= {1'b0, opA} + {1'b0, opB};
    end else if (stepsLeft != '0) begin
      stepsLeft <= stepsLeft - 1'b1;
    end
  end

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    taken |=> (sumOut == '0) && !carryOut); // R5
  AST_DONE_ON_TIME: assert property (@(posedge clk) disable iff (rst)
    (stepsLeft == CW'(1)) |=> done); // R4
  AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (rst)
    (stepsLeft != '0) |-> !done); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R4
  AST_SUM_OK: assert property (@(posedge clk) disable iff (rst)
    done |-> (sumOut == expTotal[WIDTH-1:0])); // R2
  AST_CARRY_OK: assert property (@(posedge clk) disable iff (rst)
    done |-> (carryOut == expTotal[WIDTH])); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stepsLeft == '0 && !loadStb) |=> ($stable(sumOut) && $stable(carryOut))); // R9
endmodule

bind ser_adder ser_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .loadStb  (loadStb),
  .opA      (opA),
  .opB      (opB),
  .sumOut   (sumOut),
  .carryOut (carryOut),
  .done     (done)
);

// File: tb/test_ser_adder.sv
module test_ser_adder;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       loadStb;
  logic [3:0] opA;
  logic [3:0] opB;
  logic [3:0] sumOut;
  logic       carryOut;
  logic       done;

  int total = 0;
  int bad   = 0;
  logic [4:0] expQ[$];
  logic [4:0] item;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ser_adder #(.WIDTH(4)) i_ser_adder (
    .clk      (clk),
    .rst      (rst),
    .loadStb  (loadStb),
    .opA      (opA),
    .opB      (opB),
    .sumOut   (sumOut),
    .carryOut (carryOut),
    .done     (done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: push the expected result, then pulse the strobe for one cycle
  task automatic startAdd(input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    opA     = a;
    opB     = b;
    loadStb = 1'b1;
    expQ.push_back({1'b0, a} + {1'b0, b});
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  // monitor: compare each completion against the scoreboard
  always @(negedge clk) begin
    if (!rst && done) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected done", 1, 0);
      end else begin
        item = expQ.pop_front();
        check(sumOut == item[3:0], "R2 sum", sumOut, item[3:0]);
        check(carryOut == item[4], "R3 carry", carryOut, item[4]);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; loadStb = 1'b0; opA = '0; opB = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(sumOut == 0, "R1 sum", sumOut, 0);
    check(carryOut == 0, "R1 carry", carryOut, 0);
    check(done == 0, "R1 done", done, 0);

    // 11 + 5 = 16: step by step, LSB first (R8) and done timing (R4)
    startAdd(4'd11, 4'd5);
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      check(done == 0, "R4 early", done, 0);
      check((sumOut >> (4 - k)) == (5'd16 & ((5'd1 << k) - 1)), "R8 partial",
            sumOut >> (4 - k), 5'd16 & ((5'd1 << k) - 1));
    end
    @(negedge clk);
    check(done == 1, "R4 on time", done, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(done == 0, "R4 one cycle", done, 0);
      check(sumOut == 0 && carryOut == 1, "R9 hold", {carryOut, sumOut}, 16);
    end

    // 9 + 9 = 18 leaves carry 1 and sum 2; the next load must clear both (R5)
    startAdd(4'd9, 4'd9);
    repeat (5) @(negedge clk);
    startAdd(4'd1, 4'd2);
    check(sumOut == 0 && carryOut == 0, "R5 clear", {carryOut, sumOut}, 0);
    repeat (5) @(negedge clk);

    // strobe while busy with other operands: ignored (R6)
    startAdd(4'd2, 4'd3);
    opA = 4'd15; opB = 4'd15; loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
    repeat (2) @(negedge clk);
    check(done == 0, "R6 timing", done, 0);
    @(negedge clk);
    check(done == 1, "R6 timing", done, 1);
    check(sumOut == 5 && carryOut == 0, "R6 operands", {carryOut, sumOut}, 5);
    repeat (2) @(negedge clk);

    // back-to-back: load presented during the done cycle (R7)
    startAdd(4'd7, 4'd8);
    repeat (3) @(negedge clk);
    startAdd(4'd12, 4'd13);
    check(done == 0 && sumOut == 0, "R7 accepted", {done, sumOut}, 0);
    repeat (3) @(negedge clk);
    @(negedge clk);
    check(done == 1, "R7 done", done, 1);
    repeat (2) @(negedge clk);

    // every operand pair through the scoreboard (R2, R3)
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        startAdd(4'(a), 4'(b));
        repeat (5) @(negedge clk);
      end
    end

    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R2 all results seen", expQ.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule